// File: doc/BRIEF.md
# Crossbar CNF Clause-Network Evaluator

This block decides whether a conjunctive-normal-form formula is true. The formula has a fixed number of OR clauses, each with a fixed number of literal slots. Literals arrive already evaluated, one bit per slot, packed clause by clause into a single input vector. Unused or absent literals are driven 0 by the user.

In hardware, each clause is laid out as a small switch matrix. Literal cells fill a near-square block in row-major order. A routing column and a routing row turn the matrix into a path finder: a signal entering one edge row reaches the opposite edge row only if some literal cell is closed.

The matrices are chained. Odd-numbered clauses are entered from the top and exit at the bottom. Even-numbered clauses are entered from the bottom and exit at the top. The exit of one clause feeds the entry of the next.

A start strobe captures the literal vector and walks the chain one clause per clock. After the last clause it raises a one-cycle done pulse together with the formula result. The result is taken from the sense row that the parity of the clause count selects.

Top module: `xbar_cnf_eval`

## Requirements
- R1: After reset, `done` and `result` are both 0 and stay 0 until the first evaluation completes.
- R2: Clause k uses bits `lits[k*LITS + j]`, j = 0..LITS-1. The bits are placed row-major in a block of ceil(sqrt(LITS)) columns by ceil(LITS/columns) rows. A single true literal in any slot, with the other slots 0, makes its clause true.
- R3: If any clause has all its literal bits at 0, the result of that evaluation is 0.
- R4: The result equals the AND over all clauses of the OR of each clause's literal bits.
- R5: `start` is accepted only while idle. `done` is high for exactly one cycle, N_CLAUSES clock edges after the edge that accepted `start`, and `result` updates on that same edge.
- R6: A `start` seen while an evaluation is in progress is ignored. It neither restarts nor extends the evaluation.
- R7: The literal vector is captured on the accepting edge. Later changes to `lits` do not affect that evaluation.
- R8: `result` keeps its value between `done` pulses.
- R9: Clause orientation alternates: odd-numbered clauses are entered from the top and even-numbered clauses from the bottom. The result is read at the bottom row of the final clause when N_CLAUSES is odd and at its top row when it is even. This holds for odd clause counts and for non-square LITS.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Begin an evaluation when idle |
| lits | input | N_CLAUSES*LITS | Evaluated literal bits, clause k at bits [k*LITS +: LITS] |
| done | output | 1 | One-cycle pulse when the result is valid |
| result | output | 1 | Formula value, held until the next completion |

## Verification
On every cycle, the assertions check the following:
- A clause's exit row carries signal exactly when its entry is live and one of its literals is set.
- `done` only follows the last clause step and never lasts two cycles.
- The captured literals stay frozen during a run.
- An empty clause always yields a 0 result.

Only the bench's scenarios can show the rest:
- The path through the alternating top- and bottom-entry layouts gives the AND-of-ORs for whole formulas.
- Every literal slot, including the last slot of a non-square block, is wired.
- Starts during a run and literal changes after capture leave the result untouched.

// File: rtl/xbar_cnf_pkg.sv
package xbar_cnf_pkg;

  typedef enum logic {
    ORIENT_TOP = 1'b0,
    ORIENT_BOT = 1'b1
  } orient_e;

  // smallest r with r*r >= v
  function automatic int ceil_sqrt(input int v);
    int r;
    r = 1;
    for (int i = 1; i <= v; i++) begin
      if (r * r < v) r = i + 1;
    end
    return r;
  endfunction

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

endpackage

// File: rtl/xbar_rst_sync.sv
module xbar_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/xbar_clause_layout.sv
// Builds the cell matrix of one OR clause in either orientation.
module xbar_clause_layout
  import xbar_cnf_pkg::*;
#(
  parameter int      S      = 9,
  parameter orient_e ORIENT = ORIENT_TOP,
  localparam int GCOLS = ceil_sqrt(S),
  localparam int GROWS = ceil_div(S, GCOLS),
  localparam int COLS  = GCOLS + 1,
  localparam int ROWS  = GROWS + 1
) (
  input  logic [S-1:0]         lits_i,
  output logic [ROWS*COLS-1:0] cells_o
);

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    localparam bit ROUTE_ROW = (ORIENT == ORIENT_TOP) ? (r == ROWS - 1) : (r == 0);
    localparam int LROW      = (ORIENT == ORIENT_TOP) ? r : r - 1;
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int LIDX = LROW * GCOLS + (c - 1);
      if (ROUTE_ROW) begin : g_route
        if (c == 0) begin : g_cut
          assign cells_o[r*COLS+c] = 1'b0;
        end else begin : g_link
          assign cells_o[r*COLS+c] = 1'b1;
        end
      end else if (c == 0) begin : g_spine
        assign cells_o[r*COLS+c] = 1'b1;
      end else if (LIDX < S) begin : g_lit
        assign cells_o[r*COLS+c] = lits_i[LIDX];
      end else begin : g_pad
        assign cells_o[r*COLS+c] = 1'b0;
      end
    end
  end

endmodule

// File: rtl/xbar_reach.sv
// Reachability from one row wire to another through closed cells.
module xbar_reach #(
  parameter int ROWS  = 4,
  parameter int COLS  = 4,
  parameter int ENTRY = 0,
  parameter int EXIT  = 3,
  localparam int STEPS = ROWS + COLS
) (
  input  logic [ROWS*COLS-1:0] cells_i,
  input  logic                 entry_i,
  output logic                 exit_o
);

  logic [ROWS-1:0] row_live;
  logic [COLS-1:0] col_live;

  always_comb begin
    row_live        = '0;
    row_live[ENTRY] = entry_i;
    col_live        = '0;
    for (int k = 0; k < STEPS; k++) begin
      for (int c = 0; c < COLS; c++) begin
        for (int r = 0; r < ROWS; r++) begin
          if (row_live[r] && cells_i[r*COLS+c]) col_live[c] = 1'b1;
        end
      end
      for (int r = 0; r < ROWS; r++) begin
        for (int c = 0; c < COLS; c++) begin
          if (col_live[c] && cells_i[r*COLS+c]) row_live[r] = 1'b1;
        end
      end
    end
    exit_o = row_live[EXIT];
  end

endmodule

// File: rtl/xbar_cnf_seq.sv
// Walks the clause chain one clause per cycle.
module xbar_cnf_seq #(
  parameter int N = 4,
  parameter int S = 9,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int W  = N * S
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [W-1:0]  lits_i,
  input  logic          exit_i,
  output logic [IW-1:0] idx_o,
  output logic          carry_o,
  output logic [S-1:0]  clause_o,
  output logic          done_o,
  output logic          result_o
);

  logic          run_q, run_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          carry_q, carry_d;
  logic          done_q, done_d;
  logic          result_q, result_d;
  logic [W-1:0]  snap_q;
  logic          snap_en;
  logic          last;
  logic          any_empty;

  assign last = (idx_q == IW'(N - 1));

  always_comb begin
    run_d    = run_q;
    idx_d    = idx_q;
    carry_d  = carry_q;
    done_d   = 1'b0;
    result_d = result_q;
    snap_en  = 1'b0;
    if (!run_q) begin
      if (start_i) begin
        run_d   = 1'b1;
        idx_d   = '0;
        carry_d = 1'b1;
        snap_en = 1'b1;
      end
    end else begin
      carry_d = exit_i;
      idx_d   = idx_q + 1'b1;
      if (last) begin
        run_d    = 1'b0;
        idx_d    = '0;
        done_d   = 1'b1;
        result_d = exit_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      idx_q    <= '0;
      carry_q  <= 1'b0;
      done_q   <= 1'b0;
      result_q <= 1'b0;
    end else begin
      run_q    <= run_d;
      idx_q    <= idx_d;
      carry_q  <= carry_d;
      done_q   <= done_d;
      result_q <= result_d;
    end
  end

  always_ff @(posedge clk) begin
    if (snap_en) snap_q <= lits_i;
  end

  assign idx_o    = idx_q;
  assign carry_o  = carry_q;
  assign clause_o = snap_q[idx_q*S +: S];
  assign done_o   = done_q;
  assign result_o = result_q;

  always_comb begin
    any_empty = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (snap_q[k*S +: S] == '0) any_empty = 1'b1;
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R5
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(run_q && last)); // R5
  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (idx_q <= IW'(N - 1))); // R9
  AST_SNAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !last) |=> $stable(snap_q)); // R7
  AST_EMPTY_FORCES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && any_empty) |-> !result_q); // R3
  AST_EXIT_NEEDS_LIT: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && exit_i) |-> (carry_q && (clause_o != '0))); // R4
  AST_EXIT_WHEN_LIT: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && carry_q && (clause_o != '0)) |-> exit_i); // R2
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> $stable(result_q)); // R8

endmodule

// File: rtl/xbar_cnf_eval.sv
module xbar_cnf_eval
  import xbar_cnf_pkg::*;
#(
  parameter int N_CLAUSES = 4,
  parameter int LITS      = 9,
  localparam int IW    = (N_CLAUSES > 1) ? $clog2(N_CLAUSES) : 1,
  localparam int GCOLS = ceil_sqrt(LITS),
  localparam int ROWS  = ceil_div(LITS, GCOLS) + 1,
  localparam int COLS  = GCOLS + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [N_CLAUSES*LITS-1:0] lits,
  output logic                      done,
  output logic                      result
);

  logic                 rst_n_s;
  logic [IW-1:0]        idx;
  logic                 carry;
  logic [LITS-1:0]      clause;
  logic [ROWS*COLS-1:0] cells_top;
  logic [ROWS*COLS-1:0] cells_bot;
  logic                 exit_top;
  logic                 exit_bot;
  logic                 exit_sel;

  xbar_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  xbar_clause_layout #(.S(LITS), .ORIENT(ORIENT_TOP)) lay_top_i (
    .lits_i  (clause),
    .cells_o (cells_top)
  );

  xbar_clause_layout #(.S(LITS), .ORIENT(ORIENT_BOT)) lay_bot_i (
    .lits_i  (clause),
    .cells_o (cells_bot)
  );

  // top-entry: inject row 0, sense last row
  xbar_reach #(.ROWS(ROWS), .COLS(COLS), .ENTRY(0), .EXIT(ROWS - 1)) reach_top_i (
    .cells_i (cells_top),
    .entry_i (carry),
    .exit_o  (exit_top)
  );

  // bottom-entry: inject last row, sense row 0
  xbar_reach #(.ROWS(ROWS), .COLS(COLS), .ENTRY(ROWS - 1), .EXIT(0)) reach_bot_i (
    .cells_i (cells_bot),
    .entry_i (carry),
    .exit_o  (exit_bot)
  );

  // even index = odd-numbered clause = top-entry
  assign exit_sel = idx[0] ? exit_bot : exit_top;

  xbar_cnf_seq #(.N(N_CLAUSES), .S(LITS)) seq_i (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .start_i  (start),
    .lits_i   (lits),
    .exit_i   (exit_sel),
    .idx_o    (idx),
    .carry_o  (carry),
    .clause_o (clause),
    .done_o   (done),
    .result_o (result)
  );

endmodule

// File: tb/xbar_cnf_eval_tb_top.sv
module xbar_cnf_eval_tb_top;

  localparam int NA = 4, SA = 9;
  localparam int NB = 3, SB = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_a = 1'b0, start_b = 1'b0;
  logic [NA*SA-1:0] lits_a = '0;
  logic [NB*SB-1:0] lits_b = '0;
  logic done_a, res_a, done_b, res_b;

  int n_tests = 0, n_fail = 0, cyc = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  xbar_cnf_eval #(.N_CLAUSES(NA), .LITS(SA)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start_a), .lits(lits_a),
    .done(done_a), .result(res_a));

  xbar_cnf_eval #(.N_CLAUSES(NB), .LITS(SB)) dut_b_i (
    .clk(clk), .rst_n(rst_n), .start(start_b), .lits(lits_b),
    .done(done_b), .result(res_b));

  function automatic bit cnf(input logic [63:0] v, input int n, input int s);
    bit all = 1'b1;
    for (int k = 0; k < n; k++) begin
      bit any = 1'b0;
      for (int j = 0; j < s; j++) if (v[k*s+j]) any = 1'b1;
      all = all & any;
    end
    return all;
  endfunction

  // behavioural reference models
  int rem_a, rem_b;
  logic [63:0] snap_a, snap_b;
  bit exp_done_a, exp_res_a, exp_done_b, exp_res_b;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_a = 0; exp_done_a = 0; exp_res_a = 0;
      rem_b = 0; exp_done_b = 0; exp_res_b = 0;
    end else begin
      if (rem_a > 0) begin
        rem_a--;
        if (rem_a == 0) begin exp_done_a = 1; exp_res_a = cnf(snap_a, NA, SA); end
      end else begin
        exp_done_a = 0;
        if (start_a) begin rem_a = NA; snap_a = 64'(lits_a); end
      end
      if (rem_b > 0) begin
        rem_b--;
        if (rem_b == 0) begin exp_done_b = 1; exp_res_b = cnf(snap_b, NB, SB); end
      end else begin
        exp_done_b = 0;
        if (start_b) begin rem_b = NB; snap_b = 64'(lits_b); end
      end
    end
  end

  task automatic check(input string what, input bit act, input bit exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0b expected %0b", tag, what, act, exp);
    end
  endtask

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("A done (R5)", done_a, exp_done_a);
      check("A result (R4 R8)", res_a, exp_res_a);
      check("B done (R5)", done_b, exp_done_b);
      check("B result (R9)", res_b, exp_res_b);
    end
  end

  task automatic run_a(input logic [NA*SA-1:0] v);
    @(negedge clk); lits_a = v; start_a = 1'b1;
    @(negedge clk); start_a = 1'b0;
    repeat (NA + 1) @(negedge clk);
  endtask

  task automatic run_b(input logic [NB*SB-1:0] v);
    @(negedge clk); lits_b = v; start_b = 1'b1;
    @(negedge clk); start_b = 1'b0;
    repeat (NB + 1) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    tag = "R1";
    check("A reset done", done_a, 1'b0);
    check("A reset result", res_a, 1'b0);
    check("B reset result", res_b, 1'b0);

    tag = "R4";
    run_a('1);
    run_b('1);

    // R3: one empty clause at each position
    tag = "R3";
    for (int k = 0; k < NA; k++) begin
      logic [NA*SA-1:0] v = '1;
      v[k*SA +: SA] = '0;
      run_a(v);
      check("A empty clause R3", res_a, 1'b0);
    end
    for (int k = 0; k < NB; k++) begin
      logic [NB*SB-1:0] v = '1;
      v[k*SB +: SB] = '0;
      run_b(v);
    end

    // R2: single true literal walked through every slot of every clause
    tag = "R2";
    for (int k = 0; k < NA; k++) begin
      for (int j = 0; j < SA; j++) begin
        logic [NA*SA-1:0] v = '1;
        v[k*SA +: SA] = '0;
        v[k*SA + j] = 1'b1;
        run_a(v);
        check("A single literal R2", res_a, 1'b1);
      end
    end
    // R9: odd clause count, non-square clause
    tag = "R9";
    for (int k = 0; k < NB; k++) begin
      for (int j = 0; j < SB; j++) begin
        logic [NB*SB-1:0] v = '1;
        v[k*SB +: SB] = '0;
        v[k*SB + j] = 1'b1;
        run_b(v);
        check("B single literal R9", res_b, 1'b1);
      end
    end

    // R4: mixed patterns, sparse so both outcomes occur
    tag = "R4";
    for (int t = 0; t < 40; t++) begin
      logic [NA*SA-1:0] va;
      logic [NB*SB-1:0] vb;
      va = NA*SA'({$urandom, $urandom}) & NA*SA'({$urandom, $urandom});
      vb = NB*SB'($urandom) & NB*SB'($urandom);
      run_a(va);
      run_b(vb);
    end

    // R7: literals change right after capture
    tag = "R7";
    @(negedge clk); lits_a = '1; start_a = 1'b1;
    @(negedge clk); start_a = 1'b0; lits_a = '0;
    repeat (NA + 1) @(negedge clk);
    check("A captured literals R7", res_a, 1'b1);

    // R6: start held high through a run and beyond
    tag = "R6";
    @(negedge clk); lits_a = '0; start_a = 1'b1;
    @(negedge clk); lits_a = '1;
    repeat (NA + 2) @(negedge clk);
    start_a = 1'b0;
    repeat (NA + 2) @(negedge clk);

    // R8: result hold checked every cycle over idle stretch
    tag = "R8";
    lits_a = '0;
    repeat (10) @(negedge clk);
    check("A result held R8", res_a, 1'b1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule